// File: doc/BRIEF.md
# Write-Strobe Qualification Guard

This block sits between the asynchronous chip-select, output-enable and write-strobe pins of a flash memory and its command decoder. All pins, together with the address bus, the data bus and a digital supply-good flag, are sampled by a fast system clock through a synchroniser. The block watches for the interval in which both the chip select and the write strobe are low. It measures how long that interval lasts and checks that nothing forbids a write during it.

A write that survives every check leaves the block as a single-cycle pulse. The pulse carries the address captured when the low interval began and the data present just before it ended. Writes are discarded in four cases: the low interval is too short to be a real strobe, output enable drops, the supply flag is low, or the supply has not yet been good for the power-up lockout time. A synchronous reset clears the captured values and drops any write that is in progress.

Top module: `wr_qual_guard`

## Requirements
- R1: A write is accepted when chip select and write strobe are both low (in either order of falling) with output enable high and all other conditions met. Each accepted write produces exactly one `wr_pulse` of one clock cycle, and a rejected write produces none.
- R2: `wr_addr` presents the address bus value sampled on the first cycle in which chip select and write strobe are both low, that is, at the later of the two falling edges. Later address changes during the low interval do not affect it.
- R3: `wr_data` presents the data bus value sampled on the last cycle in which both strobes are low, that is, just before the earlier of the two rising edges.
- R4: If output enable is low on any sampled cycle of the low interval, the write is rejected.
- R5: A low interval of fewer than `MIN_LOW` clock samples is rejected. One of exactly `MIN_LOW` samples is accepted.
- R6: While `vdd_good` is low, every write is rejected.
- R7: After the synchronised `vdd_good` rises, writes are rejected until it has stayed high for `PWR_DELAY` clock cycles. A drop of the flag restarts this lockout.
- R8: Reset high clears `wr_addr` and `wr_data` to zero and holds `wr_pulse` low. A low interval that was already in progress when reset was released produces no pulse.
- R9: Every input passes through `SYNC_STAGES` flops. The pulse becomes visible `SYNC_STAGES + 1` rising clock edges after the first edge that samples the strobe released at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Asynchronous chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_strobe_n | input | 1 | Asynchronous write strobe, active low |
| bus_addr | input | AW | Asynchronous address bus |
| bus_din | input | DW | Asynchronous data bus |
| vdd_good | input | 1 | Digital supply-good flag |
| wr_pulse | output | 1 | One-cycle pulse per qualified write |
| wr_addr | output | AW | Address of the last qualified write |
| wr_data | output | DW | Data of the last qualified write |

## Verification
The bench builds the block with `MIN_LOW` = 3, `PWR_DELAY` = 40 and `SYNC_STAGES` = 2. The small lockout count allows a whole power-up window, including a write rejected inside it and a restart after the flag drops, to be run in a few hundred cycles. The short minimum width places both sides of the glitch boundary (2 and 3 samples) within a single test. With a shallow synchroniser, the exact pulse latency is checked on every accepted write.

// File: rtl/wqg_pkg.sv
package wqg_pkg;

    // Qualification state of one low interval of the combined strobe
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no interval being tracked
        PH_TRACK = 2'd1,   // interval open and still eligible
        PH_SPOIL = 2'd2    // interval open but disqualified
    } phase_e;

    // Synchronised control pins
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic sup;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Combined strobe: a write window exists only while both are low
    function automatic logic both_low(input logic cs_n, input logic we_n);
        return !cs_n && !we_n;
    endfunction

endpackage

// File: rtl/wqg_sync.sv
module wqg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wqg_pwr_gate.sv
module wqg_pwr_gate #(
    parameter int PWR_DELAY = 1000
) (
    input  logic clk,
    input  logic sup_s,
    output logic armed
);

    localparam int CW = $clog2(PWR_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PWR_DELAY);

    logic [CW-1:0] cnt;

    // The supply flag is this counter's own reset: a drop restarts the lockout
    always_ff @(posedge clk) begin
        if (!sup_s) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign armed = sup_s && (cnt == LIMIT);

endmodule

// File: rtl/wqg_strobe.sv
module wqg_strobe
    import wqg_pkg::*;
#(
    parameter int AW      = 17,
    parameter int DW      = 16,
    parameter int MIN_LOW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          armed,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          pulse,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    localparam int NW = $clog2(MIN_LOW + 1) + 1;
    localparam logic [NW-1:0] NEED = NW'(MIN_LOW);

    phase_e        phase;
    logic          act;
    logic          act_q;
    logic          allow;
    logic [NW-1:0] width;
    logic [AW-1:0] stg_addr;
    logic [DW-1:0] stg_data;

    assign act   = both_low(cs_n, we_n);
    assign allow = oe_n && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            // act_q set so that an interval already open at release is not seen as a start
            act_q    <= 1'b1;
            phase    <= PH_IDLE;
            width    <= '0;
            stg_addr <= '0;
            stg_data <= '0;
            pulse    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            act_q <= act;
            pulse <= 1'b0;
            if (act && !act_q) begin
                // later falling edge: address is taken here
                stg_addr <= addr_s;
                stg_data <= data_s;
                width    <= NW'(1);
                phase    <= allow ? PH_TRACK : PH_SPOIL;
            end else if (act) begin
                stg_data <= data_s;
                if (width != NEED) begin
                    width <= width + 1'b1;
                end
                if (phase == PH_TRACK && !allow) begin
                    phase <= PH_SPOIL;
                end
            end else if (act_q) begin
                // earlier rising edge: data already holds the last low sample
                if (phase == PH_TRACK && allow && width >= NEED) begin
                    pulse  <= 1'b1;
                    addr_q <= stg_addr;
                    data_q <= stg_data;
                end
                phase <= PH_IDLE;
            end
        end
    end

endmodule

// File: rtl/wr_qual_guard.sv
module wr_qual_guard
    import wqg_pkg::*;
#(
    parameter int AW          = 17,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 3,
    parameter int PWR_DELAY   = 2000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_strobe_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din,
    input  logic          vdd_good,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam int SW = CTL_W + AW + DW;

    ctl_t          ctl_raw;
    ctl_t          ctl_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          armed;
    logic          oe_s_n;

    assign ctl_raw = '{cs_n: chip_sel_n, oe_n: out_en_n, we_n: wr_strobe_n, sup: vdd_good};

    wqg_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   ({ctl_raw, bus_addr, bus_din}),
        .q   ({ctl_s, addr_s, data_s})
    );

    wqg_pwr_gate #(
        .PWR_DELAY (PWR_DELAY)
    ) u_pwr (
        .clk   (clk),
        .sup_s (ctl_s.sup),
        .armed (armed)
    );

    assign oe_s_n = ctl_s.oe_n;

    wqg_strobe #(
        .AW      (AW),
        .DW      (DW),
        .MIN_LOW (MIN_LOW)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (ctl_s.cs_n),
        .oe_n   (oe_s_n),
        .we_n   (ctl_s.we_n),
        .armed  (armed),
        .addr_s (addr_s),
        .data_s (data_s),
        .pulse  (wr_pulse),
        .addr_q (wr_addr),
        .data_q (wr_data)
    );

endmodule

// File: rtl/wqg_checker.sv
module wqg_checker #(
    parameter int AW = 17,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_pulse,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          armed,
    input logic          oe_s_n
);

    // R1: a qualified write is a single-cycle pulse
    p_one_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

    // R4: no pulse unless output enable was high when the interval closed
    p_oe_high_r4: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(oe_s_n));

    // R6 / R7: no pulse unless the power gate was armed when the interval closed
    p_armed_r7: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(armed));

    // R8: leaving reset shows cleared outputs
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wr_pulse && wr_addr == '0 && wr_data == '0));

endmodule

bind wr_qual_guard wqg_checker #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_pulse (wr_pulse),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .armed    (armed),
    .oe_s_n   (oe_s_n)
);

// File: tb/test_wr_qual_guard.sv
`timescale 1ns/1ps
module test_wr_qual_guard;

    localparam int AW = 17;
    localparam int DW = 16;
    localparam int SYNC = 2;
    localparam int MINL = 3;
    localparam int PWRD = 40;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            cyc;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vdd = 1'b0;
    logic [AW-1:0] baddr = '0;
    logic [DW-1:0] bdin = '0;
    logic          wr_pulse;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   pulses = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wr_qual_guard #(
        .AW (AW), .DW (DW), .SYNC_STAGES (SYNC), .MIN_LOW (MINL), .PWR_DELAY (PWRD)
    ) i_wr_qual_guard (
        .clk (clk), .rst (rst), .chip_sel_n (cs_n), .out_en_n (oe_n),
        .wr_strobe_n (we_n), .bus_addr (baddr), .bus_din (bdin), .vdd_good (vdd),
        .wr_pulse (wr_pulse), .wr_addr (wr_addr), .wr_data (wr_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: pop the scoreboard on every pulse
    always @(negedge clk) begin
        if (!rst && wr_pulse) begin
            pulses++;
            if (sb.size() == 0) begin
                chk(1'b0, "R1 unexpected pulse", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(wr_addr == e.a, "R2 address", wr_addr, e.a);
                chk(wr_data == e.d, "R3 data", wr_data, e.d);
                chk(cyc == e.cyc, "R9 latency", cyc, e.cyc);
            end
        end
    end

    // we_ctl=1: chip select falls first and the write strobe closes the window
    task automatic do_write(input bit we_ctl, input logic [AW-1:0] a, input logic [DW-1:0] d1,
                            input logic [DW-1:0] d2, input int lo, input bit oe_glitch,
                            input bit exp_ok, input string req);
        int p0;
        p0 = pulses;
        @(negedge clk);
        baddr = a ^ 17'h1_0F0F;
        bdin  = d1;
        if (we_ctl) cs_n = 1'b0; else we_n = 1'b0;
        @(negedge clk);
        baddr = a;                       // valid before the later falling edge
        @(negedge clk);
        if (we_ctl) we_n = 1'b0; else cs_n = 1'b0;
        for (int i = 1; i <= lo; i++) begin
            @(negedge clk);
            if (i == lo) begin
                if (we_ctl) we_n = 1'b1; else cs_n = 1'b1;
                if (exp_ok) sb.push_back('{a: a, d: (lo >= 2) ? d2 : d1, cyc: cyc + SYNC + 1});
            end else begin
                if (i == 1) begin
                    baddr = ~a;          // must not be taken
                    bdin  = d2;
                    if (oe_glitch) oe_n = 1'b0;
                end else begin
                    oe_n = 1'b1;
                end
            end
        end
        @(negedge clk);
        cs_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        repeat (7) @(negedge clk);
        chk(pulses - p0 == (exp_ok ? 1 : 0), req, pulses - p0, exp_ok ? 1 : 0);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(!wr_pulse && wr_addr == '0 && wr_data == '0, "R8 reset state",
            {wr_pulse, wr_addr, wr_data}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        do_write(1'b1, 17'h05555, 16'h00AA, 16'h00BB, 4, 1'b0, 1'b0, "R6 supply low");
        vdd = 1'b1;
        repeat (5) @(negedge clk);
        do_write(1'b1, 17'h02AAA, 16'h0055, 16'h0066, 4, 1'b0, 1'b0, "R7 inside lockout");
        repeat (60) @(negedge clk);

        do_write(1'b1, 17'h05555, 16'h1234, 16'h00A0, 4, 1'b0, 1'b1, "R1 write-strobe controlled");
        do_write(1'b0, 17'h1F123, 16'hBEEF, 16'hCAFE, 5, 1'b0, 1'b1, "R1 chip-select controlled");
        do_write(1'b1, 17'h00042, 16'h1111, 16'h2222, MINL - 1, 1'b0, 1'b0, "R5 one sample short");
        do_write(1'b0, 17'h00043, 16'h3333, 16'h4444, MINL, 1'b0, 1'b1, "R5 exactly minimum");
        do_write(1'b1, 17'h01FFF, 16'h5555, 16'h6666, 5, 1'b1, 1'b0, "R4 output enable low");

        vdd = 1'b0;
        repeat (4) @(negedge clk);
        do_write(1'b0, 17'h03000, 16'h7777, 16'h8888, 4, 1'b0, 1'b0, "R6 supply dropped");
        vdd = 1'b1;
        do_write(1'b1, 17'h03001, 16'h9999, 16'hAAAA, 4, 1'b0, 1'b0, "R7 lockout restarted");
        repeat (60) @(negedge clk);
        do_write(1'b1, 17'h05001, 16'hABCD, 16'hDCBA, 6, 1'b0, 1'b1, "R7 after lockout");

        // R8: reset in the middle of an open interval
        begin
            int p0;
            p0 = pulses;
            @(negedge clk);
            baddr = 17'h0AAAA; bdin = 16'h0F0F;
            cs_n = 1'b0;
            @(negedge clk);
            we_n = 1'b0;
            repeat (2) @(negedge clk);
            rst = 1'b1;
            repeat (3) @(negedge clk);
            chk(wr_addr == '0 && wr_data == '0, "R8 outputs cleared", {wr_addr, wr_data}, 0);
            rst = 1'b0;
            repeat (6) @(negedge clk);
            we_n = 1'b1;
            @(negedge clk);
            cs_n = 1'b1;
            repeat (8) @(negedge clk);
            chk(pulses == p0, "R8 partial interval dropped", pulses - p0, 0);
        end
        do_write(1'b0, 17'h1ABCD, 16'h0101, 16'h0202, 4, 1'b0, 1'b1, "R8 recovery after reset");

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R1 all expected writes seen", sb.size(), 0);
        summary();
        $finish;
    end

endmodule